// File: doc/BRIEF.md
# RTC Burst-Access Register Bank

This block is the storage and transfer core of a real-time clock. It holds eight clock/calendar registers and a 31-byte scratch RAM. The last clock register is a control byte that carries a write-protect bit. A host reaches either group only through bit-serial bursts. The host raises `cs` and presents a one-cycle command (`cmd_valid` with `cmd_ram` and `cmd_rd`). After that, each pulse on `bit_stb` moves one bit. Data is sent least significant bit first and runs across consecutive bytes starting at index 0.

A clock-burst read copies all eight live registers into a shadow set in the command cycle, and then serves every bit from that copy. The timekeeping logic keeps writing the live registers through the update port (`upd_we`, `upd_idx`, `upd_data`) while the read is in progress. When the protect bit is set at the start of a write burst, the whole burst is discarded. This holds for the clock bank (including the control byte) and for the RAM.

The sequencer has five states: IDLE, READ, WRITE, WBLOCK (a write burst that is consumed but never stored) and DONE (the final byte has moved and further strobes are ignored). Its transitions are:

- IDLE to READ on a read command.
- IDLE to WRITE on a write command while protect is clear.
- IDLE to WBLOCK on a write command while protect is set.
- READ, WRITE or WBLOCK to DONE on the strobe that ends the final byte.
- Any state back to IDLE whenever `cs` is low.

Top module: `rtcb_bank`

## Requirements
- R1: A clock burst covers registers 0 through 7 in ascending order. Register 7 is the control byte, and bit 7 of it is the write-protect bit.
- R2: Bits move least significant first. While READ is active, `sdo` combinationally shows bit `b` of byte `k`. Each `bit_stb` cycle advances to the next bit.
- R3: A byte received during a write is stored only on the strobe of its eighth bit. The byte index advances only on that strobe.
- R4: When a clock-read command is accepted, all eight live registers are copied to the shadow set. The read returns shadow values even if the live registers change during the burst.
- R5: If the protect bit is 1 when a write command is accepted, nothing in the clock bank changes for that burst, including the control byte. This holds even if the burst sends a byte that would clear the bit.
- R6: A RAM burst covers RAM bytes 0 through 30 in order. Strobes after the last byte of any burst are ignored until `cs` falls.
- R7: A RAM write burst that starts while the protect bit is 1 leaves the RAM unchanged.
- R8: When `cs` is low, the sequencer goes to IDLE on the next edge. Completed bytes stay stored and a partly shifted byte is dropped.
- R9: An update pulse writes `upd_data` into live register `upd_idx` for indices 0 to 6. Index 7 is ignored. If a burst commit targets the same register in the same cycle, the burst commit wins.
- R10: `sdo` is 0 in every state other than READ.
- R11: Reset clears all clock registers (so protect is 0), the shadow set and the RAM, and returns the sequencer to IDLE with index 0.
- R12: Command encoding: `cmd_ram` = 1 selects the RAM and 0 selects the clock bank. `cmd_rd` = 1 selects a read and 0 selects a write. A command is taken only in IDLE with `cs` high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs | input | 1 | Burst enable; low aborts and returns to idle |
| cmd_valid | input | 1 | One-cycle command strobe |
| cmd_ram | input | 1 | 1 = RAM burst, 0 = clock burst |
| cmd_rd | input | 1 | 1 = read, 0 = write |
| bit_stb | input | 1 | Advance one bit this cycle |
| sdi | input | 1 | Serial write data |
| sdo | output | 1 | Serial read data |
| upd_we | input | 1 | Timekeeping update strobe |
| upd_idx | input | 3 | Live register index for the update |
| upd_data | input | 8 | Update value |

## Verification
The checker assumes that `bit_stb` and `cmd_valid` are never high in the same cycle. It also assumes that a command only appears while `cs` is high and the sequencer is idle. The bench drives its stimulus through tasks that issue the command in one cycle, clear `cmd_valid` before the first strobe, and drop `cs` between bursts. The bench schedules the update port on cycles between strobes, except in one deliberate collision. That collision is on the eighth-bit strobe of a write, so that the commit-priority rule is exercised.

// File: rtl/rtcb_pkg.sv
package rtcb_pkg;
    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_READ   = 3'd1,
        ST_WRITE  = 3'd2,
        ST_WBLOCK = 3'd3,
        ST_DONE   = 3'd4
    } seq_state_e;
endpackage

// File: rtl/rtcb_seq.sv
module rtcb_seq #(
    parameter int DW        = 8,
    parameter int CLK_REGS  = 8,
    parameter int RAM_BYTES = 31,
    localparam int MAXB     = (CLK_REGS > RAM_BYTES) ? CLK_REGS : RAM_BYTES,
    localparam int IW       = $clog2(MAXB),
    localparam int BW       = $clog2(DW)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cs,
    input  logic                    cmd_valid,
    input  logic                    cmd_ram,
    input  logic                    cmd_rd,
    input  logic                    bit_stb,
    input  logic                    sdi,
    input  logic                    wp_now,
    output rtcb_pkg::seq_state_e    state,
    output logic                    sel_ram,
    output logic [IW-1:0]           byte_idx,
    output logic [BW-1:0]           bit_idx,
    output logic                    snap,
    output logic                    commit,
    output logic [DW-1:0]           commit_data
);
    import rtcb_pkg::*;

    seq_state_e    nxt;
    logic [DW-1:0] shreg;
    logic          last_bit;
    logic          last_byte;
    logic          in_burst;
    logic          accept;

    assign last_bit  = (bit_idx == BW'(DW - 1));
    assign last_byte = sel_ram ? (byte_idx == IW'(RAM_BYTES - 1))
                               : (byte_idx == IW'(CLK_REGS - 1));
    assign in_burst  = (state == ST_READ) || (state == ST_WRITE) || (state == ST_WBLOCK);
    assign accept    = (state == ST_IDLE) && cs && cmd_valid;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // transitions
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (cs && cmd_valid)
                    nxt = cmd_rd ? ST_READ : (wp_now ? ST_WBLOCK : ST_WRITE);
            end
            ST_READ, ST_WRITE, ST_WBLOCK: begin
                if (!cs)
                    nxt = ST_IDLE;
                else if (bit_stb && last_bit && last_byte)
                    nxt = ST_DONE;
            end
            ST_DONE: begin
                if (!cs) nxt = ST_IDLE;
            end
            default: nxt = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        snap        = accept && cmd_rd && !cmd_ram;
        commit      = (state == ST_WRITE) && cs && bit_stb && last_bit;
        commit_data = {sdi, shreg[DW-1:1]};
    end

    // burst position and shifter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            byte_idx <= '0;
            bit_idx  <= '0;
            shreg    <= '0;
            sel_ram  <= 1'b0;
        end else if (state == ST_IDLE || !cs) begin
            byte_idx <= '0;
            bit_idx  <= '0;
            if (accept) sel_ram <= cmd_ram;
        end else if (in_burst && bit_stb) begin
            shreg <= {sdi, shreg[DW-1:1]};
            if (last_bit) begin
                bit_idx <= '0;
                if (!last_byte) byte_idx <= byte_idx + 1'b1;
            end else begin
                bit_idx <= bit_idx + 1'b1;
            end
        end
    end
endmodule

// File: rtl/rtcb_clkregs.sv
module rtcb_clkregs #(
    parameter int DW     = 8,
    parameter int NREG   = 8,
    parameter int WP_BIT = 7,
    localparam int RIW   = $clog2(NREG)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 upd_we,
    input  logic [RIW-1:0]       upd_idx,
    input  logic [DW-1:0]        upd_data,
    input  logic                 wr_en,
    input  logic [RIW-1:0]       wr_idx,
    input  logic [DW-1:0]        wr_data,
    input  logic                 snap,
    input  logic [RIW-1:0]       rd_idx,
    output logic [DW-1:0]        rd_data,
    output logic                 wp,
    output logic [DW-1:0]        ctrl_q,
    output logic [NREG*DW-1:0]   shadow_flat
);
    logic [DW-1:0] live [NREG];
    logic [DW-1:0] shad [NREG];

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        localparam bit IS_CTRL = (g == NREG - 1);
        logic hit_wr;
        logic hit_upd;
        assign hit_wr  = wr_en && (wr_idx == RIW'(g));
        assign hit_upd = upd_we && (upd_idx == RIW'(g)) && !IS_CTRL;

        always_ff @(posedge clk) begin
            if (!rst_n)       live[g] <= '0;
            else if (hit_wr)  live[g] <= wr_data;
            else if (hit_upd) live[g] <= upd_data;
        end

        always_ff @(posedge clk) begin
            if (!rst_n)    shad[g] <= '0;
            else if (snap) shad[g] <= live[g];
        end

        assign shadow_flat[g*DW +: DW] = shad[g];
    end

    assign rd_data = shad[rd_idx];
    assign ctrl_q  = live[NREG-1];
    assign wp      = ctrl_q[WP_BIT];
endmodule

// File: rtl/rtcb_ram.sv
module rtcb_ram #(
    parameter int DW    = 8,
    parameter int DEPTH = 31,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            we,
    input  logic [AW-1:0]   waddr,
    input  logic [DW-1:0]   wdata,
    input  logic [AW-1:0]   raddr,
    output logic [DW-1:0]   rdata
);
    logic [DW-1:0] mem [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_cell
        always_ff @(posedge clk) begin
            if (!rst_n)                          mem[g] <= '0;
            else if (we && (waddr == AW'(g)))    mem[g] <= wdata;
        end
    end

    assign rdata = (int'(raddr) < DEPTH) ? mem[raddr] : '0;
endmodule

// File: rtl/rtcb_bank.sv
module rtcb_bank #(
    parameter int DW        = 8,
    parameter int CLK_REGS  = 8,
    parameter int RAM_BYTES = 31,
    parameter int WP_BIT    = 7,
    localparam int RIW      = $clog2(CLK_REGS)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cs,
    input  logic            cmd_valid,
    input  logic            cmd_ram,
    input  logic            cmd_rd,
    input  logic            bit_stb,
    input  logic            sdi,
    output logic            sdo,
    input  logic            upd_we,
    input  logic [RIW-1:0]  upd_idx,
    input  logic [DW-1:0]   upd_data
);
    import rtcb_pkg::*;

    localparam int MAXB = (CLK_REGS > RAM_BYTES) ? CLK_REGS : RAM_BYTES;
    localparam int IW   = $clog2(MAXB);
    localparam int BW   = $clog2(DW);
    localparam int AW   = $clog2(RAM_BYTES);

    seq_state_e                 state;
    logic                       sel_ram;
    logic [IW-1:0]              byte_idx;
    logic [BW-1:0]              bit_idx;
    logic                       snap;
    logic                       commit;
    logic [DW-1:0]              commit_data;
    logic                       wp;
    logic [DW-1:0]              ctrl_q;
    logic [CLK_REGS*DW-1:0]     shadow_flat;
    logic [DW-1:0]              sh_rdata;
    logic [DW-1:0]              ram_rdata;
    logic [DW-1:0]              rd_byte;

    rtcb_seq #(.DW(DW), .CLK_REGS(CLK_REGS), .RAM_BYTES(RAM_BYTES)) u_seq (
        .clk(clk), .rst_n(rst_n), .cs(cs), .cmd_valid(cmd_valid),
        .cmd_ram(cmd_ram), .cmd_rd(cmd_rd), .bit_stb(bit_stb), .sdi(sdi),
        .wp_now(wp), .state(state), .sel_ram(sel_ram), .byte_idx(byte_idx),
        .bit_idx(bit_idx), .snap(snap), .commit(commit), .commit_data(commit_data)
    );

    rtcb_clkregs #(.DW(DW), .NREG(CLK_REGS), .WP_BIT(WP_BIT)) u_clk (
        .clk(clk), .rst_n(rst_n), .upd_we(upd_we), .upd_idx(upd_idx),
        .upd_data(upd_data), .wr_en(commit && !sel_ram),
        .wr_idx(byte_idx[RIW-1:0]), .wr_data(commit_data), .snap(snap),
        .rd_idx(byte_idx[RIW-1:0]), .rd_data(sh_rdata), .wp(wp),
        .ctrl_q(ctrl_q), .shadow_flat(shadow_flat)
    );

    rtcb_ram #(.DW(DW), .DEPTH(RAM_BYTES)) u_ram (
        .clk(clk), .rst_n(rst_n), .we(commit && sel_ram),
        .waddr(byte_idx[AW-1:0]), .wdata(commit_data),
        .raddr(byte_idx[AW-1:0]), .rdata(ram_rdata)
    );

    assign rd_byte = sel_ram ? ram_rdata : sh_rdata;
    assign sdo     = (state == ST_READ) && rd_byte[bit_idx];
endmodule

// File: rtl/rtcb_bank_chk.sv
module rtcb_bank_chk #(
    parameter int DW       = 8,
    parameter int CLK_REGS = 8,
    parameter int IW       = 5,
    parameter int BW       = 3
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      cs,
    input logic                      bit_stb,
    input logic                      sdo,
    input rtcb_pkg::seq_state_e      state,
    input logic                      sel_ram,
    input logic [IW-1:0]             byte_idx,
    input logic [BW-1:0]             bit_idx,
    input logic [DW-1:0]             ctrl_q,
    input logic [CLK_REGS*DW-1:0]    shadow_flat
);
    import rtcb_pkg::*;

    assert_sdo_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_READ) |-> !sdo);

    assert_abort_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !cs |=> (state == ST_IDLE));

    assert_block_ctrl_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WBLOCK) |=> $stable(ctrl_q));

    assert_snap_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_READ && !sel_ram) |=> (state != ST_READ || $stable(shadow_flat)));

    assert_index_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_READ || state == ST_WRITE || state == ST_WBLOCK) && cs &&
         !(bit_stb && bit_idx == BW'(DW - 1))) |=> (byte_idx == $past(byte_idx)));
endmodule

bind rtcb_bank rtcb_bank_chk #(.DW(DW), .CLK_REGS(CLK_REGS), .IW(IW), .BW(BW)) u_chk (
    .clk(clk), .rst_n(rst_n), .cs(cs), .bit_stb(bit_stb), .sdo(sdo),
    .state(state), .sel_ram(sel_ram), .byte_idx(byte_idx), .bit_idx(bit_idx),
    .ctrl_q(ctrl_q), .shadow_flat(shadow_flat)
);

// File: tb/tb_rtcb_bank.sv
`timescale 1ns/1ps
module tb_rtcb_bank;
    localparam int NCLK = 8;
    localparam int NRAM = 31;

    logic       clk = 0;
    logic       rst_n = 0;
    logic       cs = 0, cmd_valid = 0, cmd_ram = 0, cmd_rd = 0;
    logic       bit_stb = 0, sdi = 0, upd_we = 0;
    logic [2:0] upd_idx = 0;
    logic [7:0] upd_data = 0;
    logic       sdo;

    int checks = 0, failures = 0, cyc = 0;
    int wbuf[NRAM];
    int rbuf[NRAM];
    int eclk[NCLK];
    int eram[NRAM];

    always #2 clk = ~clk;

    rtcb_bank dut (
        .clk(clk), .rst_n(rst_n), .cs(cs), .cmd_valid(cmd_valid), .cmd_ram(cmd_ram),
        .cmd_rd(cmd_rd), .bit_stb(bit_stb), .sdi(sdi), .sdo(sdo),
        .upd_we(upd_we), .upd_idx(upd_idx), .upd_data(upd_data)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // behavioural reference: mode 0 idle, 1 read, 2 write, 3 blocked, 4 done
    int m_mode, m_ram, m_byte, m_bit, m_sh;
    int m_live[NCLK];
    int m_shad[NCLK];
    int m_mem[NRAM];

    always @(posedge clk) begin
        int cw, cv, cr;
        cw = -1; cv = 0; cr = 0;
        if (!rst_n) begin
            m_mode = 0; m_ram = 0; m_byte = 0; m_bit = 0; m_sh = 0;
            foreach (m_live[i]) begin m_live[i] = 0; m_shad[i] = 0; end
            foreach (m_mem[i]) m_mem[i] = 0;
        end else begin
            if (!cs) begin
                m_mode = 0; m_byte = 0; m_bit = 0;
            end else begin
                case (m_mode)
                    0: if (cmd_valid) begin
                        m_ram = cmd_ram; m_byte = 0; m_bit = 0;
                        if (cmd_rd) begin
                            m_mode = 1;
                            if (m_ram == 0) foreach (m_shad[i]) m_shad[i] = m_live[i];
                        end else begin
                            m_mode = ((m_live[7] >> 7) & 1) ? 3 : 2;
                        end
                    end
                    1, 2, 3: if (bit_stb) begin
                        if (sdi) m_sh = m_sh | (1 << m_bit);
                        else     m_sh = m_sh & ~(1 << m_bit);
                        if (m_bit == 7) begin
                            if (m_mode == 2) begin cw = m_byte; cv = m_sh & 255; cr = m_ram; end
                            m_bit = 0;
                            if (m_byte == (m_ram ? NRAM - 1 : NCLK - 1)) m_mode = 4;
                            else m_byte++;
                        end else m_bit++;
                    end
                    default: ;
                endcase
            end
            if (upd_we && upd_idx < 7) m_live[upd_idx] = upd_data;
            if (cw >= 0) begin
                if (cr) m_mem[cw] = cv;
                else    m_live[cw] = cv;
            end
        end
    end

    always @(negedge clk) begin
        int e;
        if (rst_n) begin
            if (m_mode == 1) begin
                e = ((m_ram ? m_mem[m_byte] : m_shad[m_byte]) >> m_bit) & 1;
                chk("R2 sdo vs model", sdo, e);
            end else begin
                chk("R10 sdo idle", sdo, 0);
            end
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=%0d expected<150000", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic begin_burst(input bit ram, input bit rd);
        @(negedge clk);
        cs = 1; cmd_valid = 1; cmd_ram = ram; cmd_rd = rd;
        @(negedge clk);
        cmd_valid = 0;
    endtask

    task automatic end_burst();
        cs = 0;
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic send_bits(input int v, input int nb);
        for (int i = 0; i < nb; i++) begin
            sdi = (v >> i) & 1;
            bit_stb = 1;
            @(negedge clk);
            bit_stb = 0;
            sdi = 0;
        end
    endtask

    task automatic rd_bytes(input int first, input int n);
        for (int k = first; k < first + n; k++) begin
            int v;
            v = 0;
            for (int b = 0; b < 8; b++) begin
                v = v | (int'(sdo) << b);
                bit_stb = 1;
                @(negedge clk);
                bit_stb = 0;
            end
            rbuf[k] = v;
        end
    endtask

    task automatic write_burst(input bit ram, input int n);
        begin_burst(ram, 0);
        for (int i = 0; i < n; i++) send_bits(wbuf[i], 8);
        end_burst();
    endtask

    task automatic read_burst(input bit ram, input int n);
        begin_burst(ram, 1);
        rd_bytes(0, n);
        end_burst();
    endtask

    task automatic upd(input int idx, input int val);
        upd_we = 1; upd_idx = 3'(idx); upd_data = 8'(val);
        @(negedge clk);
        upd_we = 0;
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk("R11 sdo after reset", sdo, 0);

        // R11: reset contents
        read_burst(0, NCLK);
        for (int i = 0; i < NCLK; i++) chk("R11 clock reg reset", rbuf[i], 0);
        read_burst(1, NRAM);
        for (int i = 0; i < NRAM; i++) chk("R11 ram reset", rbuf[i], 0);

        // R1 R2 R12: clock write then read, protect clear
        for (int i = 0; i < NCLK; i++) begin
            eclk[i] = (i == 0) ? 8'h01 : (i == 7) ? 8'h05 : 8'h11 * (i + 1);
            wbuf[i] = eclk[i];
        end
        write_burst(0, NCLK);
        begin_burst(0, 1);
        chk("R2 first bit is lsb", sdo, 1);
        rd_bytes(0, NCLK);
        end_burst();
        for (int i = 0; i < NCLK; i++) chk("R1 clock readback", rbuf[i], eclk[i]);

        // R6: RAM burst plus extra strobes ignored
        for (int i = 0; i < NRAM; i++) begin eram[i] = (i * 7 + 3) & 255; wbuf[i] = eram[i]; end
        begin_burst(1, 0);
        for (int i = 0; i < NRAM; i++) send_bits(wbuf[i], 8);
        send_bits(8'hFF, 8);
        end_burst();
        read_burst(1, NRAM);
        for (int i = 0; i < NRAM; i++) chk("R6 ram readback", rbuf[i], eram[i]);

        // R8 R3: abort mid byte
        begin_burst(0, 0);
        send_bits(8'hA5, 8);
        send_bits(8'h5A, 8);
        send_bits(8'hFF, 3);
        end_burst();
        eclk[0] = 8'hA5; eclk[1] = 8'h5A;
        read_burst(0, NCLK);
        for (int i = 0; i < NCLK; i++) chk("R8 abort keeps whole bytes", rbuf[i], eclk[i]);
        begin_burst(0, 0);
        send_bits(8'h3C, 7);
        end_burst();
        read_burst(0, 1);
        chk("R3 seven bits do not commit", rbuf[0], eclk[0]);

        // R4: snapshot while live regs change
        begin_burst(0, 1);
        rd_bytes(0, 1);
        upd(1, 8'h99);
        upd(0, 8'h42);
        rd_bytes(1, NCLK - 1);
        end_burst();
        for (int i = 0; i < NCLK; i++) chk("R4 snapshot bytes", rbuf[i], eclk[i]);
        eclk[0] = 8'h42; eclk[1] = 8'h99;
        read_burst(0, NCLK);
        chk("R9 live reg0 updated", rbuf[0], 8'h42);
        chk("R9 live reg1 updated", rbuf[1], 8'h99);

        // R9: index 7 ignored on update port
        upd(7, 8'hFF);
        read_burst(0, NCLK);
        chk("R9 ctrl untouched by update", rbuf[7], eclk[7]);

        // R9: collision, burst commit wins
        begin_burst(0, 0);
        send_bits(8'h6C, 7);
        sdi = 0; bit_stb = 1; upd_we = 1; upd_idx = 0; upd_data = 8'h33;
        @(negedge clk);
        bit_stb = 0; upd_we = 0;
        end_burst();
        eclk[0] = 8'h6C;
        read_burst(0, 1);
        chk("R9 burst wins collision", rbuf[0], 8'h6C);

        // R1 R5: set protect via control byte, then blocked write
        for (int i = 0; i < NCLK; i++) begin eclk[i] = (i == 7) ? 8'h80 : 8'h20 + i; wbuf[i] = eclk[i]; end
        write_burst(0, NCLK);
        read_burst(0, NCLK);
        chk("R1 protect bit stored", rbuf[7], 8'h80);
        for (int i = 0; i < NCLK; i++) wbuf[i] = 0;
        write_burst(0, NCLK);
        read_burst(0, NCLK);
        for (int i = 0; i < NCLK; i++) chk("R5 blocked clock write", rbuf[i], eclk[i]);

        // R7: RAM write blocked
        for (int i = 0; i < NRAM; i++) wbuf[i] = 8'hEE;
        write_burst(1, NRAM);
        read_burst(1, NRAM);
        for (int i = 0; i < NRAM; i++) chk("R7 blocked ram write", rbuf[i], eram[i]);

        // R12: command ignored while cs low
        @(negedge clk);
        cmd_valid = 1; cmd_rd = 1; cmd_ram = 0;
        @(negedge clk);
        cmd_valid = 0;
        @(negedge clk);
        chk("R12 no command without cs", sdo, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule